// File: doc/BRIEF.md
# Staged Instruction Control Generator

This block turns the opcode of the instruction sitting in the decode stage of a five-stage processor into the nine control bits that the later stages need. It does the decoding once. The bits are then split by the stage that uses them and carried down the decode/execute, execute/memory and memory/write-back registers next to the instruction they belong to. A group is dropped once the stage that reads it has passed. The instruction's destination register number travels with the controls, so a write lands in the register of the instruction that produced it. This still holds when several writing instructions are in flight at once.

The register-register class, word load, word store and equal-compare branch are decoded. Every other opcode gives all-zero control. A hazard unit can ask for a bubble when a load result is not yet ready. A branch resolver can ask for a flush when a taken branch kills the instruction in decode. Either request turns the slot that enters decode/execute into a no-operation. The ALU, the register file and the memories are outside this block.

Top module: `pctl_top`

## Requirements
- R1: Opcode 0x00 (register-register) yields, in execute: destination-from-rd=1, ALU mode=2'b10, immediate operand=0. In memory it yields branch=0, read=0, write=0. In write-back it yields register write=1, load select=0.
- R2: Opcode 0x23 (load) yields destination-from-rd=0, ALU mode=2'b00, immediate operand=1, branch=0, read=1, write=0, register write=1, load select=1.
- R3: Opcode 0x2B (store) yields ALU mode=2'b00, immediate operand=1, write=1, with branch, read and register write at 0. Its don't-care bits (destination-from-rd, load select) are driven 0.
- R4: Opcode 0x04 (branch) yields ALU mode=2'b01, immediate operand=0, branch=1, with read, write and register write at 0. Its don't-care bits are driven 0.
- R5: Any other opcode produces all nine control bits at 0.
- R6: The execute-stage outputs show the decode of the opcode presented one rising edge earlier. The memory-stage outputs show that same instruction one edge after that, and the write-back outputs one edge after that again.
- R7: The execute-stage destination is rd when destination-from-rd is 1 and rt otherwise. That number is carried unchanged to the memory and write-back stages with its instruction.
- R8: A bubble request sampled at an edge loads all-zero controls and register numbers into decode/execute, whatever the opcode. The instructions already in later stages move on unaffected.
- R9: A flush request has the same effect on decode/execute as a bubble request. It also leaves the older stages unaffected.
- R10: A synchronous active-high reset clears every stage output to zero at the next edge, whatever the inputs.
- R11: Back-to-back writing instructions each keep their own destination through all stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_rt | input | 5 | Second source / load target register field |
| id_rd | input | 5 | Register-register destination field |
| id_bubble | input | 1 | Insert a no-operation into decode/execute |
| id_flush | input | 1 | Kill the instruction in decode |
| ex_dst_rd | output | 1 | Execute: destination comes from rd |
| ex_alu_mode | output | 2 | Execute: ALU operation class |
| ex_alu_imm | output | 1 | Execute: second ALU operand is the immediate |
| ex_dest | output | 5 | Execute: selected destination register |
| mem_branch | output | 1 | Memory: instruction is a branch |
| mem_rd_en | output | 1 | Memory: data read |
| mem_wr_en | output | 1 | Memory: data write |
| mem_dest | output | 5 | Memory: destination register |
| wb_reg_wr | output | 1 | Write-back: register file write |
| wb_load_sel | output | 1 | Write-back: write data comes from memory |
| wb_dest | output | 5 | Write-back: destination register |

## Verification
A value presented in decode is due at the execute outputs after one rising edge, at the memory outputs after two and at write-back after three. The bench drives inputs on falling edges and samples on the next falling edge. It advances a three-slot expected pipeline built from the requirements at each edge. Every stage is compared on every step, so a bubble, flush or reset is checked both in the slot it clears and in the older slots it must leave alone.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
    parameter int OP_W  = 6;
    parameter int REG_W = 5;

    localparam logic [OP_W-1:0] OPC_RRR   = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

    typedef struct packed {
        logic       dst_rd;
        logic [1:0] alu_mode;
        logic       alu_imm;
    } ex_ctl_t;

    typedef struct packed {
        logic branch;
        logic rd_en;
        logic wr_en;
    } mem_ctl_t;

    typedef struct packed {
        logic reg_wr;
        logic load_sel;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_t;

    typedef struct packed {
        ex_ctl_t          ex;
        mem_ctl_t         mem;
        wb_ctl_t          wb;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
    } idex_t;

    typedef struct packed {
        mem_ctl_t         mem;
        wb_ctl_t          wb;
        logic [REG_W-1:0] dest;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t          wb;
        logic [REG_W-1:0] dest;
    } memwb_t;

    typedef struct packed {
        idex_t  idex;
        exmem_t exmem;
        memwb_t memwb;
    } pipe_t;
endpackage

// File: rtl/pctl_decode.sv
module pctl_decode
    import pctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RRR: begin
                ctl.ex.dst_rd   = 1'b1;
                ctl.ex.alu_mode = 2'b10;
                ctl.wb.reg_wr   = 1'b1;
            end
            OPC_LOAD: begin
                ctl.ex.alu_imm  = 1'b1;
                ctl.mem.rd_en   = 1'b1;
                ctl.wb.reg_wr   = 1'b1;
                ctl.wb.load_sel = 1'b1;
            end
            OPC_STORE: begin
                ctl.ex.alu_imm  = 1'b1;
                ctl.mem.wr_en   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.ex.alu_mode = 2'b01;
                ctl.mem.branch  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/pctl_pipe.sv
module pctl_pipe
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             dec,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rd,
    input  logic             kill,
    output pipe_t            pipe_q,
    output logic [REG_W-1:0] ex_dest
);
    pipe_t pipe_d;

    always_comb begin
        ex_dest = pipe_q.idex.ex.dst_rd ? pipe_q.idex.rd : pipe_q.idex.rt;

        pipe_d = pipe_q;
        if (kill) begin
            pipe_d.idex = '0;
        end else begin
            pipe_d.idex.ex  = dec.ex;
            pipe_d.idex.mem = dec.mem;
            pipe_d.idex.wb  = dec.wb;
            pipe_d.idex.rt  = rt;
            pipe_d.idex.rd  = rd;
        end
        pipe_d.exmem.mem  = pipe_q.idex.mem;
        pipe_d.exmem.wb   = pipe_q.idex.wb;
        pipe_d.exmem.dest = ex_dest;
        pipe_d.memwb.wb   = pipe_q.exmem.wb;
        pipe_d.memwb.dest = pipe_q.exmem.dest;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    // R8
    kill_clears_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> (pipe_q.idex == '0));

    // R6
    mem_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pipe_q.exmem.mem == $past(pipe_q.idex.mem)));

    // R7
    wb_dest_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pipe_q.memwb.dest == $past(pipe_q.exmem.dest)));

    // R5
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pipe_q.exmem.mem.branch, pipe_q.exmem.mem.rd_en, pipe_q.exmem.mem.wr_en}));

    // R2
    load_writes_chk: assert property (@(posedge clk) disable iff (rst)
        pipe_q.memwb.wb.load_sel |-> pipe_q.memwb.wb.reg_wr);
endmodule

// File: rtl/pctl_top.sv
module pctl_top
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  id_opcode,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_bubble,
    input  logic             id_flush,
    output logic             ex_dst_rd,
    output logic [1:0]       ex_alu_mode,
    output logic             ex_alu_imm,
    output logic [REG_W-1:0] ex_dest,
    output logic             mem_branch,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [REG_W-1:0] mem_dest,
    output logic             wb_reg_wr,
    output logic             wb_load_sel,
    output logic [REG_W-1:0] wb_dest
);
    ctl_t  dec_ctl;
    pipe_t pipe_q;

    pctl_decode u_dec (
        .opcode (id_opcode),
        .ctl    (dec_ctl)
    );

    pctl_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec_ctl),
        .rt      (id_rt),
        .rd      (id_rd),
        .kill    (id_bubble | id_flush),
        .pipe_q  (pipe_q),
        .ex_dest (ex_dest)
    );

    assign ex_dst_rd   = pipe_q.idex.ex.dst_rd;
    assign ex_alu_mode = pipe_q.idex.ex.alu_mode;
    assign ex_alu_imm  = pipe_q.idex.ex.alu_imm;
    assign mem_branch  = pipe_q.exmem.mem.branch;
    assign mem_rd_en   = pipe_q.exmem.mem.rd_en;
    assign mem_wr_en   = pipe_q.exmem.mem.wr_en;
    assign mem_dest    = pipe_q.exmem.dest;
    assign wb_reg_wr   = pipe_q.memwb.wb.reg_wr;
    assign wb_load_sel = pipe_q.memwb.wb.load_sel;
    assign wb_dest     = pipe_q.memwb.dest;
endmodule

// File: tb/sim_pctl_top.sv
module sim_pctl_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] id_opcode = '0;
    logic [4:0] id_rt = '0;
    logic [4:0] id_rd = '0;
    logic       id_bubble = 1'b0;
    logic       id_flush = 1'b0;
    logic       ex_dst_rd, ex_alu_imm, mem_branch, mem_rd_en, mem_wr_en;
    logic       wb_reg_wr, wb_load_sel;
    logic [1:0] ex_alu_mode;
    logic [4:0] ex_dest, mem_dest, wb_dest;

    int total = 0;
    int bad = 0;

    // expected pipeline: ex {dst_rd, mode[1:0], imm}, mem {br, rd, wr}, wb {rw, ls}
    logic [3:0] m_ex = '0;
    logic [2:0] m_mem = '0, m_mem_n = '0;
    logic [1:0] m_wb = '0, m_wb_n = '0, m_wb_e = '0;
    logic [4:0] m_exd = '0, m_memd = '0, m_wbd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pctl_top u0 (
        .clk(clk), .rst(rst), .id_opcode(id_opcode), .id_rt(id_rt), .id_rd(id_rd),
        .id_bubble(id_bubble), .id_flush(id_flush),
        .ex_dst_rd(ex_dst_rd), .ex_alu_mode(ex_alu_mode), .ex_alu_imm(ex_alu_imm),
        .ex_dest(ex_dest), .mem_branch(mem_branch), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_dest(mem_dest), .wb_reg_wr(wb_reg_wr),
        .wb_load_sel(wb_load_sel), .wb_dest(wb_dest)
    );

    // full decode from the requirements: {dst_rd, mode, imm, br, rd, wr, rw, ls}
    function automatic logic [8:0] ref_dec(input logic [5:0] op);
        case (op)
            6'h00:   return 9'b1_10_0_000_10; // R1
            6'h23:   return 9'b0_00_1_010_11; // R2
            6'h2B:   return 9'b0_00_1_001_00; // R3
            6'h04:   return 9'b0_01_0_100_00; // R4
            default: return 9'b0;              // R5
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one edge: drive at the falling edge, advance model, compare at the next falling edge
    task automatic step(input string req, input logic [5:0] op, input logic [4:0] rt,
                        input logic [4:0] rd, input logic bub, input logic fl);
        logic [8:0] d;
        id_opcode = op; id_rt = rt; id_rd = rd; id_bubble = bub; id_flush = fl;
        @(posedge clk);
        d = ref_dec(op);
        if (rst) begin
            m_ex = '0; m_exd = '0; m_mem = '0; m_memd = '0; m_wb = '0; m_wbd = '0;
        end else begin
            m_wb = m_wb_n; m_wbd = m_memd;
            m_wb_n = m_wb_e; m_mem = m_mem_n; m_memd = m_exd;
            if (bub || fl) begin
                m_mem_n = '0; m_wb_e = '0; m_ex = '0; m_exd = '0;
            end else begin
                m_ex = d[8:5]; m_mem_n = d[4:2]; m_wb_e = d[1:0];
                m_exd = d[8] ? rd : rt;
            end
        end
        if (rst) begin m_mem_n = '0; m_wb_n = '0; m_wb_e = '0; end
        @(negedge clk);
        check(req, "ex ctl", {ex_dst_rd, ex_alu_mode, ex_alu_imm}, m_ex);
        check(req, "ex dest", ex_dest, m_exd);
        check(req, "mem ctl", {mem_branch, mem_rd_en, mem_wr_en}, m_mem);
        check(req, "mem dest", mem_dest, m_memd);
        check(req, "wb ctl", {wb_reg_wr, wb_load_sel}, m_wb);
        check(req, "wb dest", wb_dest, m_wbd);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3; i++) step(req, 6'h3F, 5'd0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step("R10", 6'h00, 5'd3, 5'd9, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_rformat;
        step("R1", 6'h00, 5'd4, 5'd17, 1'b0, 1'b0);
        drain("R6");
    endtask

    task automatic t_load;
        step("R2", 6'h23, 5'd12, 5'd30, 1'b0, 1'b0);
        drain("R6");
    endtask

    task automatic t_store;
        step("R3", 6'h2B, 5'd8, 5'd21, 1'b0, 1'b0);
        drain("R3");
    endtask

    task automatic t_branch;
        step("R4", 6'h04, 5'd3, 5'd1, 1'b0, 1'b0);
        drain("R4");
    endtask

    task automatic t_unknown;
        step("R5", 6'h08, 5'd7, 5'd7, 1'b0, 1'b0);
        step("R5", 6'h3F, 5'd31, 5'd31, 1'b0, 1'b0);
        step("R5", 6'h22, 5'd2, 5'd6, 1'b0, 1'b0);
        drain("R5");
    endtask

    task automatic t_bubble;
        step("R8", 6'h23, 5'd2, 5'd0, 1'b0, 1'b0);
        step("R8", 6'h00, 5'd5, 5'd4, 1'b1, 1'b0);
        step("R8", 6'h00, 5'd5, 5'd4, 1'b0, 1'b0);
        drain("R8");
    endtask

    task automatic t_flush;
        step("R9", 6'h04, 5'd1, 5'd3, 1'b0, 1'b0);
        step("R9", 6'h23, 5'd11, 5'd0, 1'b0, 1'b1);
        step("R9", 6'h2B, 5'd6, 5'd0, 1'b0, 1'b1);
        drain("R9");
    endtask

    task automatic t_back_to_back;
        step("R11", 6'h00, 5'd1, 5'd2, 1'b0, 1'b0);
        step("R11", 6'h23, 5'd3, 5'd4, 1'b0, 1'b0);
        step("R7", 6'h00, 5'd5, 5'd6, 1'b0, 1'b0);
        step("R7", 6'h23, 5'd31, 5'd7, 1'b0, 1'b0);
        drain("R11");
    endtask

    task automatic t_mid_reset;
        step("R10", 6'h00, 5'd9, 5'd10, 1'b0, 1'b0);
        step("R10", 6'h23, 5'd11, 5'd12, 1'b0, 1'b0);
        rst = 1'b1;
        step("R10", 6'h00, 5'd13, 5'd14, 1'b0, 1'b0);
        rst = 1'b0;
        step("R10", 6'h2B, 5'd15, 5'd16, 1'b0, 1'b0);
        drain("R10");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rformat();
        t_load();
        t_store();
        t_branch();
        t_unknown();
        t_bubble();
        t_flush();
        t_back_to_back();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule